// File: doc/BRIEF.md
# Sized Load/Store Lane Aligner

This block sits between an execute stage and a 32-bit, word-addressed data memory. Each request supplies a base register value and a 13-bit signed constant; the block adds them to form the byte address and hands the memory the word address. Stores leave the block in the same cycle as the request, with a byte-enable mask and the write data copied into the selected byte lanes. Loads take the word the memory returns for that address, pick out the addressed byte, halfword or word, and zero- or sign-extend it to 32 bits. The result is registered and presented one cycle later.

Byte lanes are little-endian. An access that is not aligned to its own size, or that uses an unknown operation code, is not carried out. It raises a fault pulse one cycle after the request, and it neither writes memory nor returns load data.

Top module: `lsu_lane_aligner`

## Requirements
- R1: The byte address is base plus the 13-bit constant sign-extended to 32 bits, wrapping modulo 2^32. `mem_word_addr` is byte address bits 31:2, driven in the request cycle.
- R2: With a zero base, constant 0x0FFF reaches byte address 0x00000FFF and constant 0x1000 reaches 0xFFFFF000, the top and bottom 4K of the space.
- R3: A word store (`req_is_store`=1, `req_kind`=0) at an aligned address asserts `mem_we` with `mem_be`=4'b1111 and `mem_wdata` equal to the source register, in the request cycle.
- R4: A halfword store (`req_kind`=1) copies the source's low 16 bits into both halves of `mem_wdata`. It sets `mem_be` to 4'b0011 when address bit 1 is 0 and to 4'b1100 when it is 1.
- R5: A byte store (`req_kind`=2) copies the source's low 8 bits into all four lanes. It sets the single `mem_be` bit whose index equals address bits 1:0, where lane n is `mem_wdata` bits 8n+7:8n.
- R6: Load codes are 0 word, 1 halfword unsigned, 2 halfword signed, 3 byte unsigned and 4 byte signed. A byte load takes lane address[1:0] of `mem_rdata`, and a halfword load takes bits 31:16 when address bit 1 is set and bits 15:0 otherwise.
- R7: Unsigned loads clear every bit above the loaded field. Signed loads copy the field's top bit into all of them.
- R8: `ld_valid` is high for exactly the cycle after an accepted load request, with `ld_data` holding the result. Stores and idle cycles leave `ld_valid` low and `ld_data` unchanged.
- R9: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, pulses `fault` one cycle after the request. It keeps `mem_we` low and `mem_be` at zero, gives no `ld_valid`, and leaves `ld_data` unchanged.
- R10: Load codes 5 to 7 and store codes 3 to 7 are treated like a misaligned access: they pulse `fault`, do not write and return no data.
- R11: Synchronous active-high `rst` clears `ld_valid`, `ld_data` and `fault`. When `req_valid` is low, `mem_we` is 0 and `mem_be` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_kind | input | 3 | Access size and extension code |
| base_val | input | 32 | Base register value |
| ofs_imm | input | 13 | Signed constant offset |
| store_src | input | 32 | Register value to store |
| mem_rdata | input | 32 | Word read from memory at `mem_word_addr` |
| mem_word_addr | output | 30 | Word address to memory |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-lane write enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| ld_valid | output | 1 | Load result valid (registered) |
| ld_data | output | 32 | Extended load result (registered) |
| fault | output | 1 | Misaligned or illegal request (registered) |

## Verification
The bench targets lane selection in every position and sign extension from fields whose top bit is set and clear. A design with swapped endianness, or one that always zero-extends, returns the wrong upper bits. It also drives the offset at both of its signed extremes with a zero base, and a base near the top of the space so the address wraps. A design that zero-extends the constant, or drops the carry, lands on the wrong word. Misaligned halfword and word accesses and unused operation codes are checked for a suppressed write and an unchanged load result, which catches a design that writes or returns data anyway.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [2:0] {
    LK_WORD = 3'd0,
    LK_HALF_U = 3'd1,
    LK_HALF_S = 3'd2,
    LK_BYTE_U = 3'd3,
    LK_BYTE_S = 3'd4
  } load_kind_e;

  typedef enum logic [2:0] {
    SK_WORD = 3'd0,
    SK_HALF = 3'd1,
    SK_BYTE = 3'd2
  } store_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      legal;
    acc_size_e size;
    logic      sext;
  } acc_dec_t;

  function automatic acc_dec_t decode_kind(input logic is_store, input logic [2:0] kind);
    acc_dec_t d;
    d = '{legal: 1'b1, size: SZ_WORD, sext: 1'b0};
    if (is_store) begin
      unique case (kind)
        SK_WORD: d.size = SZ_WORD;
        SK_HALF: d.size = SZ_HALF;
        SK_BYTE: d.size = SZ_BYTE;
        default: d.legal = 1'b0;
      endcase
    end else begin
      unique case (kind)
        LK_WORD:   d.size = SZ_WORD;
        LK_HALF_U: d.size = SZ_HALF;
        LK_HALF_S: begin d.size = SZ_HALF; d.sext = 1'b1; end
        LK_BYTE_U: d.size = SZ_BYTE;
        LK_BYTE_S: begin d.size = SZ_BYTE; d.sext = 1'b1; end
        default:   d.legal = 1'b0;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int AW = 32,
  parameter int OFS_W = 13
) (
  input  logic [AW-1:0]    base_val,
  input  logic [OFS_W-1:0] ofs_imm,
  output logic [AW-1:0]    eff_addr
);
  localparam int EXT_W = AW - OFS_W;

  logic [AW-1:0] ofs_ext;

  always_comb begin
    ofs_ext  = {{EXT_W{ofs_imm[OFS_W-1]}}, ofs_imm};
    eff_addr = base_val + ofs_ext;
  end
endmodule

// File: rtl/lsu_access_check.sv
module lsu_access_check
  import lsu_pkg::*;
#(
  parameter int LB = 2
) (
  input  logic          req_is_store,
  input  logic [2:0]    req_kind,
  input  logic [LB-1:0] addr_lo,
  output acc_dec_t      dec,
  output logic          ok
);
  logic aligned;

  always_comb begin
    dec = decode_kind(req_is_store, req_kind);
    unique case (dec.size)
      SZ_WORD: aligned = (addr_lo == '0);
      SZ_HALF: aligned = ~addr_lo[0];
      default: aligned = 1'b1;
    endcase
    ok = dec.legal & aligned;
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  acc_size_e              size,
  input  logic                   enable,
  input  logic [$clog2(DW/8)-1:0] addr_lo,
  input  logic [DW-1:0]          store_src,
  output logic [DW/8-1:0]        be,
  output logic [DW-1:0]          wdata
);
  localparam int LANES = DW / 8;
  localparam int LB = $clog2(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          wdata[8*i +: 8] = store_src[7:0];
          be[i] = enable & (addr_lo == LB'(i));
        end
        SZ_HALF: begin
          wdata[8*i +: 8] = store_src[8*(i%2) +: 8];
          be[i] = enable & (addr_lo[LB-1] == ((i / 2) % 2 == 1));
        end
        default: begin
          wdata[8*i +: 8] = store_src[8*i +: 8];
          be[i] = enable;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic                    bad,
  input  acc_size_e               size,
  input  logic                    sext,
  input  logic [$clog2(DW/8)-1:0] addr_lo,
  input  logic [DW-1:0]           mem_rdata,
  output logic                    ld_valid,
  output logic [DW-1:0]           ld_data,
  output logic                    fault
);
  localparam int LB = $clog2(DW / 8);

  logic [7:0]    byte_sel;
  logic [15:0]   half_sel;
  logic [DW-1:0] ext_val;

  always_comb begin
    byte_sel = mem_rdata[8*addr_lo +: 8];
    half_sel = mem_rdata[16*addr_lo[LB-1] +: 16];
    unique case (size)
      SZ_BYTE: ext_val = {{(DW-8){sext & byte_sel[7]}}, byte_sel};
      SZ_HALF: ext_val = {{(DW-16){sext & half_sel[15]}}, half_sel};
      default: ext_val = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
      fault    <= 1'b0;
    end else begin
      ld_valid <= take;
      fault    <= bad;
      if (take) ld_data <= ext_val;
    end
  end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
  import lsu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OFS_W = 13
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         req_is_store,
  input  logic [2:0]                   req_kind,
  input  logic [AW-1:0]                base_val,
  input  logic [OFS_W-1:0]             ofs_imm,
  input  logic [DW-1:0]                store_src,
  input  logic [DW-1:0]                mem_rdata,
  output logic [AW-$clog2(DW/8)-1:0]   mem_word_addr,
  output logic                         mem_we,
  output logic [DW/8-1:0]              mem_be,
  output logic [DW-1:0]                mem_wdata,
  output logic                         ld_valid,
  output logic [DW-1:0]                ld_data,
  output logic                         fault
);
  localparam int LANES = DW / 8;
  localparam int LB = $clog2(LANES);

  logic [AW-1:0] eff_addr;
  acc_dec_t      dec;
  logic          acc_ok;
  logic          do_store;
  logic          do_load;
  logic          do_fault;

  lsu_agen #(.AW(AW), .OFS_W(OFS_W)) u_agen (
    .base_val (base_val),
    .ofs_imm  (ofs_imm),
    .eff_addr (eff_addr)
  );

  lsu_access_check #(.LB(LB)) u_chk_acc (
    .req_is_store (req_is_store),
    .req_kind     (req_kind),
    .addr_lo      (eff_addr[LB-1:0]),
    .dec          (dec),
    .ok           (acc_ok)
  );

  always_comb begin
    do_store = req_valid & req_is_store & acc_ok;
    do_load  = req_valid & ~req_is_store & acc_ok;
    do_fault = req_valid & ~acc_ok;
  end

  assign mem_word_addr = eff_addr[AW-1:LB];
  assign mem_we = do_store;

  lsu_store_lane #(.DW(DW)) u_store (
    .size      (dec.size),
    .enable    (do_store),
    .addr_lo   (eff_addr[LB-1:0]),
    .store_src (store_src),
    .be        (mem_be),
    .wdata     (mem_wdata)
  );

  lsu_load_extract #(.DW(DW)) u_load (
    .clk       (clk),
    .rst       (rst),
    .take      (do_load),
    .bad       (do_fault),
    .size      (dec.size),
    .sext      (dec.sext),
    .addr_lo   (eff_addr[LB-1:0]),
    .mem_rdata (mem_rdata),
    .ld_valid  (ld_valid),
    .ld_data   (ld_data),
    .fault     (fault)
  );
endmodule

// File: rtl/lsu_lane_aligner_chk.sv
module lsu_lane_aligner_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OFS_W = 13
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_is_store,
  input logic [2:0]                 req_kind,
  input logic [AW-1:0]              base_val,
  input logic [OFS_W-1:0]           ofs_imm,
  input logic [DW-1:0]              store_src,
  input logic [AW-$clog2(DW/8)-1:0] mem_word_addr,
  input logic                       mem_we,
  input logic [DW/8-1:0]            mem_be,
  input logic [DW-1:0]              mem_wdata,
  input logic                       ld_valid,
  input logic                       fault
);
  logic [AW-1:0] ea;
  assign ea = base_val + {{(AW-OFS_W){ofs_imm[OFS_W-1]}}, ofs_imm};

  // R1: word address follows the sign-extended sum
  p_word_addr_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> mem_word_addr == ea[AW-1:2]);

  // R3: aligned word store enables every lane with the source data
  p_word_store_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_store && req_kind == 3'd0 && ea[1:0] == 2'b00)
      |-> (mem_we && mem_be == '1 && mem_wdata == store_src));

  // R5: byte store enables exactly one lane
  p_byte_one_lane_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_store && req_kind == 3'd2)
      |-> ($countones(mem_be) == 1 && mem_be[ea[1:0]]));

  // R9: misaligned halfword store never writes
  p_half_misalign_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_store && req_kind == 3'd1 && ea[0]) |-> (!mem_we && mem_be == '0));

  // R8: a valid load result always follows a load request
  p_valid_after_load_r8: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(req_valid && !req_is_store));

  // R9: fault and load result never coincide
  p_fault_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(ld_valid && fault));

  // R11: idle cycles drive no write
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!mem_we && mem_be == '0));
endmodule

bind lsu_lane_aligner lsu_lane_aligner_chk #(.AW(AW), .DW(DW), .OFS_W(OFS_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_is_store  (req_is_store),
  .req_kind      (req_kind),
  .base_val      (base_val),
  .ofs_imm       (ofs_imm),
  .store_src     (store_src),
  .mem_word_addr (mem_word_addr),
  .mem_we        (mem_we),
  .mem_be        (mem_be),
  .mem_wdata     (mem_wdata),
  .ld_valid      (ld_valid),
  .fault         (fault)
);

// File: tb/sim_lsu_lane_aligner.sv
module sim_lsu_lane_aligner;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_is_store;
  logic [2:0]  req_kind;
  logic [31:0] base_val;
  logic [12:0] ofs_imm;
  logic [31:0] store_src;
  logic [31:0] mem_rdata;
  logic [29:0] mem_word_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        fault;

  int checks = 0;
  int errors = 0;
  logic [31:0] prev_ld;

  always #5 clk = ~clk;

  lsu_lane_aligner u0 (.*);

  typedef struct packed {
    logic        st;
    logic [2:0]  kind;
    logic [31:0] base;
    logic [12:0] ofs;
    logic [31:0] src;
    logic [31:0] rd;
    logic [29:0] wa;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] ld;
    logic        flt;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] RD = 32'h8C7B_F041;
  localparam int NV = 24;
  localparam vec_t TAB [NV] = '{
    '{1'b0, 3'd0, 32'h1000, 13'h0004, 32'h0, RD, 30'h401, 4'h0, 32'h0, 32'h8C7BF041, 1'b0, 4'd6},  // R6 word
    '{1'b0, 3'd1, 32'h1000, 13'h0002, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'h00008C7B, 1'b0, 4'd7},  // R7 hu
    '{1'b0, 3'd2, 32'h1000, 13'h0002, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'hFFFF8C7B, 1'b0, 4'd7},  // R7 hs
    '{1'b0, 3'd2, 32'h1000, 13'h0000, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'hFFFFF041, 1'b0, 4'd6},  // R6 low half
    '{1'b0, 3'd1, 32'h1000, 13'h0000, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'h0000F041, 1'b0, 4'd7},  // R7
    '{1'b0, 3'd3, 32'h1000, 13'h0001, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'h000000F0, 1'b0, 4'd6},  // R6 lane1
    '{1'b0, 3'd4, 32'h1000, 13'h0001, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'hFFFFFFF0, 1'b0, 4'd7},  // R7 bs
    '{1'b0, 3'd4, 32'h1000, 13'h0002, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'h0000007B, 1'b0, 4'd7},  // R7 positive
    '{1'b0, 3'd3, 32'h1000, 13'h0003, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'h0000008C, 1'b0, 4'd6},  // R6 lane3
    '{1'b0, 3'd4, 32'h1000, 13'h0003, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'hFFFFFF8C, 1'b0, 4'd7},  // R7
    '{1'b1, 3'd0, 32'h2000, 13'h1FF8, 32'hDEADBEEF, RD, 30'h7FE, 4'hF, 32'hDEADBEEF, 32'h0, 1'b0, 4'd3}, // R3 neg ofs
    '{1'b1, 3'd1, 32'h2000, 13'h0002, 32'h1234ABCD, RD, 30'h800, 4'hC, 32'hABCDABCD, 32'h0, 1'b0, 4'd4}, // R4 high
    '{1'b1, 3'd1, 32'h2000, 13'h0000, 32'h1234ABCD, RD, 30'h800, 4'h3, 32'hABCDABCD, 32'h0, 1'b0, 4'd4}, // R4 low
    '{1'b1, 3'd2, 32'h2000, 13'h0003, 32'h3C3C3C5A, RD, 30'h800, 4'h8, 32'h5A5A5A5A, 32'h0, 1'b0, 4'd5}, // R5 lane3
    '{1'b1, 3'd2, 32'h2000, 13'h0001, 32'h3C3C3C5A, RD, 30'h800, 4'h2, 32'h5A5A5A5A, 32'h0, 1'b0, 4'd5}, // R5 lane1
    '{1'b1, 3'd0, 32'h2000, 13'h0002, 32'h11111111, RD, 30'h800, 4'h0, 32'h0, 32'h0, 1'b1, 4'd9},       // R9 word st
    '{1'b0, 3'd0, 32'h1000, 13'h0001, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'h0, 1'b1, 4'd9},               // R9 word ld
    '{1'b0, 3'd2, 32'h1000, 13'h0003, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'h0, 1'b1, 4'd9},               // R9 half ld
    '{1'b1, 3'd1, 32'h2000, 13'h0001, 32'h22222222, RD, 30'h800, 4'h0, 32'h0, 32'h0, 1'b1, 4'd9},       // R9 half st
    '{1'b0, 3'd5, 32'h1000, 13'h0000, 32'h0, RD, 30'h400, 4'h0, 32'h0, 32'h0, 1'b1, 4'd10},              // R10 ld code
    '{1'b1, 3'd3, 32'h2000, 13'h0000, 32'h33333333, RD, 30'h800, 4'h0, 32'h0, 32'h0, 1'b1, 4'd10},      // R10 st code
    '{1'b0, 3'd3, 32'h0, 13'h0FFF, 32'h0, RD, 30'h3FF, 4'h0, 32'h0, 32'h0000008C, 1'b0, 4'd2},           // R2 bottom 4K
    '{1'b1, 3'd2, 32'h0, 13'h1000, 32'h000000A5, RD, 30'h3FFFFC00, 4'h1, 32'hA5A5A5A5, 32'h0, 1'b0, 4'd2}, // R2 top 4K
    '{1'b1, 3'd0, 32'hFFFFFFFC, 13'h0008, 32'h01020304, RD, 30'h1, 4'hF, 32'h01020304, 32'h0, 1'b0, 4'd1} // R1 wrap
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_is_store = 1'b0; req_kind = 3'd0;
    base_val = '0; ofs_imm = '0; store_src = '0; mem_rdata = RD;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(ld_valid == 1'b0, "R11 ld_valid", 32'(ld_valid), 32'h0);
    chk(fault == 1'b0, "R11 fault", 32'(fault), 32'h0);
    chk(ld_data == 32'h0, "R11 ld_data", ld_data, 32'h0);
    rst = 1'b0;
    prev_ld = 32'h0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TAB[i];
      req_valid = 1'b1; req_is_store = v.st; req_kind = v.kind;
      base_val = v.base; ofs_imm = v.ofs; store_src = v.src; mem_rdata = v.rd;
      #1;
      chk(mem_word_addr == v.wa, $sformatf("R%0d row %0d word addr", v.req, i), 32'(mem_word_addr), 32'(v.wa));
      chk(mem_we == (v.st && !v.flt), $sformatf("R%0d row %0d we", v.req, i), 32'(mem_we), 32'(v.st && !v.flt));
      chk(mem_be == v.be, $sformatf("R%0d row %0d be", v.req, i), 32'(mem_be), 32'(v.be));
      if (v.st && !v.flt)
        chk(mem_wdata == v.wd, $sformatf("R%0d row %0d wdata", v.req, i), mem_wdata, v.wd);
      @(negedge clk);
      chk(fault == v.flt, $sformatf("R%0d row %0d fault", v.req, i), 32'(fault), 32'(v.flt));
      chk(ld_valid == (!v.st && !v.flt), $sformatf("R8 row %0d ld_valid", i), 32'(ld_valid), 32'(!v.st && !v.flt));
      if (!v.st && !v.flt) begin
        chk(ld_data == v.ld, $sformatf("R%0d row %0d ld_data", v.req, i), ld_data, v.ld);
        prev_ld = v.ld;
      end else begin
        chk(ld_data == prev_ld, $sformatf("R%0d row %0d ld_data held", v.req, i), ld_data, prev_ld);
      end
    end

    // R8 / R11: idle cycle after a load drops valid and keeps data
    req_valid = 1'b1; req_is_store = 1'b0; req_kind = 3'd4;
    base_val = 32'h40; ofs_imm = 13'h0; mem_rdata = 32'h0000_0080;
    @(negedge clk);
    chk(ld_data == 32'hFFFFFF80, "R7 sign from bit 7", ld_data, 32'hFFFFFF80);
    idle();
    #1;
    chk(mem_we == 1'b0 && mem_be == 4'h0, "R11 idle no write", {27'h0, mem_we, mem_be}, 32'h0);
    @(negedge clk);
    chk(ld_valid == 1'b0, "R8 single-cycle valid", 32'(ld_valid), 32'h0);
    chk(ld_data == 32'hFFFFFF80, "R8 data held when idle", ld_data, 32'hFFFFFF80);

    // R11: reset after activity clears registered outputs
    req_valid = 1'b1; req_kind = 3'd7;
    rst = 1'b1;
    @(negedge clk);
    chk(ld_data == 32'h0 && !ld_valid && !fault, "R11 reset mid-run", ld_data, 32'h0);
    idle();
    rst = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule